// File: doc/BRIEF.md
# SDRAM Mode-Driven Burst Sequencer

This block keeps the mode configuration of a synchronous DRAM and turns each read or write command into a stream of column addresses. A 13-bit mode word is loaded through a load strobe. The load is taken only when the surrounding controller reports that every bank is idle, and only when the word carries no reserved code. The captured word sets four things: the burst length, the ordering of columns inside a burst, the read latency, and whether writes are cut down to a single location.

Commands arrive on a valid/ready stream that carries a write flag and a 9-bit start column. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The sender must hold the command stable until that cycle. `cmd_ready` is low in three cases: while a burst still has beats to issue, during the lockout that follows a successful load, and in any cycle where a load strobe is present.

The column stream on the other side has no ready signal. It issues one column per cycle and cannot be stalled. Read data valid is produced in step with the read columns, delayed by the programmed latency. Full page bursts run until the terminate input is raised.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `col_valid`, `rd_valid`, `busy` and `ld_err` are low and `cmd_ready` is high. The configuration in force is burst length 1, sequential order, latency 2, and writes following the programmed length.
- R2: A load is accepted only when `all_idle` is high, `busy` is low and the word has no reserved code. Any other load leaves the configuration unchanged and raises `ld_err` for one cycle, in the cycle after the strobe.
- R3: The following codes are reserved:
  - bits [2:0] equal to 100, 101 or 110;
  - bits [2:0] equal to 111 while bit 3 is 1;
  - bits [6:4] with any value other than 010 or 011;
  - bits [8:7] not equal to 00;
  - bits [12:10] not equal to 000.
- R4: Bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. A burst issues one column per cycle, starting in the cycle after the command is taken. `col_last` is high on the final beat.
- R5: With bit 3 equal to 0 (sequential order), beat k of a burst of length L from start column S addresses (S & ~(L-1)) | ((S+k) & (L-1)). The address wraps inside the aligned block.
- R6: With bit 3 equal to 1 (interleaved order), beat k addresses (S & ~(L-1)) | ((S^k) & (L-1)).
- R7: Bits [2:0] equal to 111 with bit 3 equal to 0 select a full page burst. It steps through the 512 columns, wrapping from 511 to 0. It keeps going until a beat on which `term` is high; that beat is the last one and carries `col_last`.
- R8: With bit 9 equal to 1, every write burst is one beat long, including under full page mode. Reads keep the programmed length. With bit 9 equal to 0, writes use the programmed length.
- R9: Bits [6:4] equal to 010 give latency 2 and 011 give latency 3. `rd_valid` is high exactly L cycles after each cycle that issues a read column, and at no other time. Write columns never produce `rd_valid`.
- R10: After an accepted load, `busy` is high for the next 2 cycles and `cmd_ready` is low during them. A load attempted during that window is rejected under R2.
- R11: `cmd_ready` is low whenever `ld_valid` is high, so a load wins over a command offered in the same cycle. `cmd_ready` is high on the last beat of a burst, so a held command starts on the very next cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe for the mode word |
| ld_word | input | 13 | Mode word |
| all_idle | input | 1 | High when every bank is idle |
| busy | output | 1 | Lockout after an accepted load |
| ld_err | output | 1 | One-cycle pulse for a rejected load |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_col | input | 9 | Start column |
| term | input | 1 | Ends a full page burst on the current beat |
| col_valid | output | 1 | Column address valid |
| col_addr | output | 9 | Column address |
| col_write | output | 1 | Current beat belongs to a write |
| col_last | output | 1 | Current beat is the last of its burst |
| rd_valid | output | 1 | Read data valid, latency-aligned |

## Verification
The two functions that can meet in one cycle are a mode load and a command handshake. The bench raises `ld_valid` and `cmd_valid` together while the sequencer is idle and checks the following:
- `cmd_ready` is low in that cycle;
- no column appears in the following cycles;
- `busy` covers the two lockout cycles;
- the held command then starts with the newly loaded length and latency.

A second overlap is a new command meeting the final beat of a running burst. It is provoked by holding `cmd_valid` through a burst. It is judged by a column stream and a `rd_valid` stream with no gap between the two bursts.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int MODE_W = 13;

  typedef struct packed {
    logic       full;
    logic       inter;
    logic       lat3;
    logic       wr_single;
    logic [1:0] len_lg;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{full: 1'b0, inter: 1'b0, lat3: 1'b0,
                                 wr_single: 1'b0, len_lg: 2'd0};

  function automatic logic mode_reserved(input logic [MODE_W-1:0] w);
    logic bad;
    bad = 1'b0;
    if (w[2] && (w[1:0] != 2'b11)) bad = 1'b1;
    if ((w[2:0] == 3'b111) && w[3]) bad = 1'b1;
    if ((w[6:4] != 3'b010) && (w[6:4] != 3'b011)) bad = 1'b1;
    if (w[8:7] != 2'b00) bad = 1'b1;
    if (w[12:10] != 3'b000) bad = 1'b1;
    return bad;
  endfunction

  function automatic cfg_t mode_decode(input logic [MODE_W-1:0] w);
    cfg_t c;
    c.full      = (w[2:0] == 3'b111);
    c.inter     = w[3];
    c.lat3      = w[4];
    c.wr_single = w[9];
    c.len_lg    = w[1:0];
    return c;
  endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter int LOCK_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [MODE_W-1:0] ld_word,
  input  logic              all_idle,
  output cfg_t              cfg,
  output logic              busy,
  output logic              ld_err
);
  localparam int LCW = $clog2(LOCK_CYC + 1);

  logic [LCW-1:0] lock_q;
  cfg_t           cfg_q;
  logic           err_q;
  logic           accept;

  assign busy   = (lock_q != '0);
  assign accept = ld_valid && all_idle && !busy && !mode_reserved(ld_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      lock_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= ld_valid && !accept;
      if (accept) begin
        cfg_q  <= mode_decode(ld_word);
        lock_q <= LCW'(LOCK_CYC);
      end else if (busy) begin
        lock_q <= lock_q - 1'b1;
      end
    end
  end

  assign cfg    = cfg_q;
  assign ld_err = err_q;

endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             blocked,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             term,
  output logic             cmd_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_write,
  output logic             col_last,
  output logic             col_lat3
);
  logic [COL_W-1:0] start_q, mask_q, cnt_q;
  logic             inter_q, full_q, write_q, lat3_q, valid_q;
  logic             single, take, last_w;
  logic [COL_W-1:0] mask_new, step;

  function automatic logic [COL_W-1:0] order_addr(
      input logic [COL_W-1:0] s, input logic [COL_W-1:0] m,
      input logic il, input logic [COL_W-1:0] k);
    logic [COL_W-1:0] off;
    off = il ? (s ^ k) : (s + k);
    return (s & ~m) | (off & m);
  endfunction

  assign single   = cmd_write && cfg.wr_single;
  assign mask_new = single   ? '0 :
                    cfg.full ? '1 :
                    ((COL_W'(1) << cfg.len_lg) - COL_W'(1));

  assign last_w    = valid_q && (full_q ? term : (cnt_q == mask_q));
  assign cmd_ready = !blocked && (!valid_q || last_w);
  assign take      = cmd_valid && cmd_ready;
  assign step      = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      inter_q <= 1'b0;
      full_q  <= 1'b0;
      write_q <= 1'b0;
      lat3_q  <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
      start_q <= cmd_col;
      mask_q  <= mask_new;
      cnt_q   <= '0;
      inter_q <= cfg.inter;
      full_q  <= cfg.full && !single;
      write_q <= cmd_write;
      lat3_q  <= cfg.lat3;
    end else if (last_w) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      cnt_q <= step;
    end
  end

  assign col_valid = valid_q;
  assign col_addr  = order_addr(start_q, mask_q, inter_q, cnt_q);
  assign col_write = write_q;
  assign col_last  = last_w;
  assign col_lat3  = lat3_q;

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int MAX_LAT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue,
  input  logic [$clog2(MAX_LAT+1)-1:0] lat,
  output logic                       rd_valid
);
  localparam int LW = $clog2(MAX_LAT + 1);

  logic [MAX_LAT-1:0] v_q;
  logic [LW-1:0]      l_q [MAX_LAT];
  logic [MAX_LAT-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= '0;
      l_q[0]  <= '0;
    end else begin
      v_q[0] <= issue;
      l_q[0] <= lat;
    end
  end

  for (genvar i = 1; i < MAX_LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i] <= 1'b0;
        l_q[i] <= '0;
      end else begin
        v_q[i] <= v_q[i-1];
        l_q[i] <= l_q[i-1];
      end
    end
  end

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_tap
    assign hit[i] = v_q[i] && (l_q[i] == LW'(i + 1));
  end

  assign rd_valid = |hit;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W    = 9,
  parameter int LOCK_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [12:0]      ld_word,
  input  logic             all_idle,
  output logic             busy,
  output logic             ld_err,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             term,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_write,
  output logic             col_last,
  output logic             rd_valid
);
  localparam int MAX_LAT = 3;
  localparam int LW      = $clog2(MAX_LAT + 1);

  cfg_t          cfg;
  logic          col_lat3;
  logic [LW-1:0] lat;

  sbs_mode_reg #(.LOCK_CYC(LOCK_CYC)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_word  (ld_word),
    .all_idle (all_idle),
    .cfg      (cfg),
    .busy     (busy),
    .ld_err   (ld_err)
  );

  sbs_burst_gen #(.COL_W(COL_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .blocked   (busy || ld_valid),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_col   (cmd_col),
    .term      (term),
    .cmd_ready (cmd_ready),
    .col_valid (col_valid),
    .col_addr  (col_addr),
    .col_write (col_write),
    .col_last  (col_last),
    .col_lat3  (col_lat3)
  );

  assign lat = col_lat3 ? LW'(3) : LW'(2);

  sbs_rd_pipe #(.MAX_LAT(MAX_LAT)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (col_valid && !col_write),
    .lat      (lat),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic clk,
  input logic rst_n,
  input logic ld_valid,
  input logic all_idle,
  input logic busy,
  input logic ld_err,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic col_valid,
  input logic col_write,
  input logic col_last,
  input logic rd_valid
);
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R10
  AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_valid && all_idle)); // R10
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !cmd_ready); // R11
  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> col_valid); // R11
  AST_NOT_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !all_idle) |=> ld_err); // R2
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R4
  AST_RD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(col_valid && !col_write, 2) ||
                  $past(col_valid && !col_write, 3))); // R9
endmodule

bind sdram_burst_seq sbs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .all_idle  (all_idle),
  .busy      (busy),
  .ld_err    (ld_err),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .col_valid (col_valid),
  .col_write (col_write),
  .col_last  (col_last),
  .rd_valid  (rd_valid)
);

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [12:0] ld_word = '0;
  logic        all_idle = 1'b1;
  logic        busy, ld_err;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [8:0]  cmd_col = '0;
  logic        term = 1'b0;
  logic        col_valid, col_write, col_last, rd_valid;
  logic [8:0]  col_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_word(ld_word),
    .all_idle(all_idle), .busy(busy), .ld_err(ld_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .term(term), .col_valid(col_valid),
    .col_addr(col_addr), .col_write(col_write), .col_last(col_last),
    .rd_valid(rd_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input int s, input int k, input int len,
                                  input bit il);
    int m = len - 1;
    int off = il ? (s ^ k) : (s + k);
    return ((s & ~m) | (off & m)) & 511;
  endfunction

  task automatic load(input logic [12:0] w, input bit idle, input bit exp_err,
                      input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_word = w; all_idle = idle;
    @(posedge clk); #1;
    ld_valid = 1'b0; all_idle = 1'b1;
    check({req, " ld_err"}, ld_err, exp_err);
    if (!exp_err) begin
      check("R10 busy first", busy, 1);
      @(posedge clk); #1;
      check("R10 busy second", busy, 1);
      check("R10 ready low", cmd_ready, 0);
      @(posedge clk); #1;
      check("R10 busy cleared", busy, 0);
    end
  endtask

  // full: full-page mode, term raised on beat len-1
  task automatic burst(input bit wr, input int col, input int len, input bit il,
                       input int lat, input bit full, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = 9'(col);
    #1 check({req, " ready"}, cmd_ready, 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int j = 0; j < len + lat + 1; j++) begin
      term = 1'b0;
      #0;
      check({req, " col_valid"}, col_valid, (j < len) ? 1 : 0);
      if (j < len) begin
        check({req, " col_addr"}, col_addr, exp_addr(col, j, full ? 512 : len, il));
        check({req, " col_write"}, col_write, wr);
        if (full && j == len - 1) begin
          term = 1'b1;
          #1;
        end
        check({req, " col_last"}, col_last, (j == len - 1) ? 1 : 0);
      end
      check("R9 rd_valid", rd_valid, (!wr && j >= lat && j - lat < len) ? 1 : 0);
      @(posedge clk); #1;
    end
    term = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 col_valid", col_valid, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 busy", busy, 0);
    check("R1 ld_err", ld_err, 0);
    check("R1 cmd_ready", cmd_ready, 1);
    burst(1'b0, 5, 1, 1'b0, 2, 1'b0, "R1 default");
    burst(1'b1, 7, 1, 1'b0, 2, 1'b0, "R1 default wr");
  endtask

  task automatic t_lengths();
    load(13'h021, 1'b1, 1'b0, "R4 bl2");
    burst(1'b0, 3, 2, 1'b0, 2, 1'b0, "R4 bl2 rd");
    load(13'h032, 1'b1, 1'b0, "R5 bl4");
    burst(1'b0, 6, 4, 1'b0, 3, 1'b0, "R5 bl4 seq wrap");
    load(13'h023, 1'b1, 1'b0, "R4 bl8");
    burst(1'b0, 13, 8, 1'b0, 2, 1'b0, "R4 bl8 seq");
  endtask

  task automatic t_interleave();
    load(13'h02B, 1'b1, 1'b0, "R6 load");
    burst(1'b0, 29, 8, 1'b1, 2, 1'b0, "R6 bl8 inter");
    burst(1'b1, 29, 8, 1'b1, 2, 1'b0, "R6 bl8 inter wr");
    load(13'h03A, 1'b1, 1'b0, "R6 load4");
    burst(1'b0, 2, 4, 1'b1, 3, 1'b0, "R6 bl4 inter");
  endtask

  task automatic t_full_page();
    load(13'h027, 1'b1, 1'b0, "R7 load");
    burst(1'b0, 510, 5, 1'b0, 2, 1'b1, "R7 page wrap");
    burst(1'b1, 100, 3, 1'b0, 2, 1'b1, "R7 page wr");
  endtask

  task automatic t_write_single();
    load(13'h223, 1'b1, 1'b0, "R8 load");
    burst(1'b1, 9, 1, 1'b0, 2, 1'b0, "R8 wr single");
    burst(1'b0, 9, 8, 1'b0, 2, 1'b0, "R8 rd keeps len");
    load(13'h227, 1'b1, 1'b0, "R8 page load");
    burst(1'b1, 40, 1, 1'b0, 2, 1'b0, "R8 page wr single");
    load(13'h223, 1'b1, 1'b0, "R8 reload");
  endtask

  task automatic t_rejects();
    load(13'h021, 1'b0, 1'b1, "R2 not idle");
    load(13'h024, 1'b1, 1'b1, "R3 bl100");
    load(13'h026, 1'b1, 1'b1, "R3 bl110");
    load(13'h02F, 1'b1, 1'b1, "R3 page inter");
    load(13'h013, 1'b1, 1'b1, "R3 lat001");
    load(13'h043, 1'b1, 1'b1, "R3 lat100");
    load(13'h0A3, 1'b1, 1'b1, "R3 op bits");
    load(13'h423, 1'b1, 1'b1, "R3 top bits");
    check("R2 no busy", busy, 0);
    burst(1'b0, 0, 8, 1'b0, 2, 1'b0, "R2 cfg kept");
    burst(1'b1, 0, 1, 1'b0, 2, 1'b0, "R2 cfg kept wr");
  endtask

  task automatic t_lockout();
    @(negedge clk);
    ld_valid = 1'b1; ld_word = 13'h032;
    @(posedge clk); #1;
    check("R10 accept", ld_err, 0);
    check("R10 busy", busy, 1);
    ld_word = 13'h021;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    check("R10 load in lockout rejected", ld_err, 1);
    @(posedge clk); #1;
    check("R10 busy over", busy, 0);
    burst(1'b0, 1, 4, 1'b0, 3, 1'b0, "R10 first cfg kept");
  endtask

  task automatic t_collision();
    @(negedge clk);
    ld_valid = 1'b1; ld_word = 13'h022;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 9'd0;
    #1 check("R11 load wins ready", cmd_ready, 0);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    check("R11 no column", col_valid, 0);
    check("R11 ld ok", ld_err, 0);
    @(posedge clk); #1;
    check("R11 still held", col_valid, 0);
    @(posedge clk); #1;
    check("R11 ready after lockout", cmd_ready, 1);
    check("R11 not started", col_valid, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int j = 0; j < 6; j++) begin
      check("R11 col_valid", col_valid, (j < 4) ? 1 : 0);
      if (j < 4) check("R11 col_addr", col_addr, j);
      check("R11 rd_valid", rd_valid, (j >= 2) ? 1 : 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_back_to_back();
    load(13'h021, 1'b1, 1'b0, "R11 b2b load");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 9'd4;
    @(posedge clk); #1;
    cmd_col = 9'd10;
    check("R11 b2b ready mid", cmd_ready, 0);
    check("R11 b2b a0", col_addr, 4);
    @(posedge clk); #1;
    check("R11 b2b a1", col_addr, 5);
    check("R11 b2b ready last", cmd_ready, 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    check("R11 b2b b0 valid", col_valid, 1);
    check("R11 b2b b0", col_addr, 10);
    check("R9 b2b rd", rd_valid, 1);
    @(posedge clk); #1;
    check("R11 b2b b1", col_addr, 11);
    check("R9 b2b rd", rd_valid, 1);
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #1;
      check("R9 b2b rd tail", rd_valid, (j < 2) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #0;
    t_reset();
    t_lengths();
    t_interleave();
    t_full_page();
    t_write_single();
    t_rejects();
    t_lockout();
    t_collision();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule